// File: doc/BRIEF.md
# PWM Timer Channel with Duty FIFO

A single pulse-width-modulated output channel. A 12-bit prescaler slows the clock for a 16-bit counter, and that counter runs either as a sawtooth from zero to the period value or as a triangle that climbs to the period and falls back to zero. The output level comes from comparing the counter with an active duty value. One of five compare actions applies the comparison, and a direct level override can replace its result.

The duty value has two possible sources, chosen by a control bit. In register mode it comes from a shadow compare register. In FIFO mode each write to the compare register queues a new value in an eight-entry FIFO. The channel copies a new duty value only at a period boundary, so no pulse is cut short or stretched. When the FIFO runs dry the last value stays in use. Sticky pending flags record counter overflow, compare match and FIFO drain. Each flag has its own interrupt enable. The overflow interrupt also needs a global enable.

Software drives the channel through a small register port with five addresses. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `pwm_fifo_channel`

## Requirements
- R1: Address 1 holds the period P (16 bits, reset 0xFFFF; a write of 0 is ignored). Address 0 is timer control: bit1 enable, bit2 up-down mode, bits[27:16] prescale N. In sawtooth mode (bit2 = 0) the enabled counter steps every N+1 clocks through 0..P and then returns to 0. With action 2 the output is high for duty×(N+1) clocks in every period of (P+1)(N+1) clocks.
- R2: In up-down mode (bit2 = 1) the counter goes 0..P and then back down to 0, so one period is 2P counts. With action 2 the output is high for (2D−1)(N+1) clocks per period when D ≥ 1, and never when D = 0.
- R3: Address 3 is channel control: bit0 duty source, bits[3:1] action, bit4 match interrupt enable, bit5 drain interrupt enable. The actions are: 0 constant low, 1 constant high, 2 high while count < duty, 3 low while count < duty, 4 toggle on each count step that equals the duty value.
- R4: With bit0 of address 3 set, a write to address 2 (duty in bits[15:0]) pushes that duty onto the FIFO. Each period boundary pops one entry and makes it the active duty. An empty FIFO leaves the last duty in use.
- R5: The FIFO holds 8 entries. Status (address 4) bit0 reads 1 when it is full and bit1 reads 1 when it is empty. A push to a full FIFO is discarded.
- R6: A duty write whose value is larger than the current period is ignored. It changes neither the shadow register nor the FIFO.
- R7: While the channel is enabled, the active duty changes only at a period boundary. While it is disabled in register mode, the active duty follows the shadow register.
- R8: Status bit2 is the overflow pending flag. It sets at the wrap from P to 0 in sawtooth mode, and when the count reaches 0 on the way down in up-down mode. It drives irq_o only when both timer-control bit3 (overflow enable) and bit4 (global enable) are set.
- R9: Status bit3 (compare match) and status bit4 (FIFO drained by a pop) drive irq_o when their enables are set. Writing 1 to bits 2 to 4 of address 4 clears the matching pending flags.
- R10: Writing 1 to timer-control bit0 starts a soft reset. The bit reads back 1 for one cycle and then clears itself. The soft reset clears the counter, the FIFO, the pending flags and the active duty.
- R11: Bit16 of address 2 turns on the output override, and bit17 then sets the level of pwm_o directly, whatever the action.
- R12: After reset, pwm_o and irq_o are 0, the period reads 0xFFFF and the status reads 0x2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | Interrupt request |

## Verification
A table of configurations runs the counter in both modes at several prescale and period values, with the duty set to zero, to a midpoint and to the period. The bench counts the output's high clocks over whole periods. Sawtooth and triangle shapes give different counts, and so does each compare action, so one mis-decoded mode or action changes the number. Directed sequences stream eight distinct duties through the FIFO and compare them period by period. Those sequences also show that an overfill is dropped and the last value is held, that a duty change made mid-period waits for the boundary, and that an up-down overflow is flagged at zero rather than at the period.

// File: rtl/pwm_fifo_pkg.sv
package pwm_fifo_pkg;
  localparam int A_TCTRL  = 0;
  localparam int A_PERIOD = 1;
  localparam int A_DUTY   = 2;
  localparam int A_CHCTRL = 3;
  localparam int A_STATUS = 4;

  // timer control bits
  localparam int TC_SRST    = 0;
  localparam int TC_EN      = 1;
  localparam int TC_UD      = 2;
  localparam int TC_OVFIE   = 3;
  localparam int TC_GIE     = 4;
  localparam int TC_PRE_LSB = 16;
  // duty register bits
  localparam int DU_OVR_EN  = 16;
  localparam int DU_OVR_LVL = 17;
  // channel control bits
  localparam int CC_FIFO    = 0;
  localparam int CC_ACT_LSB = 1;
  localparam int CC_EVTIE   = 4;
  localparam int CC_EMPIE   = 5;
  // status bits
  localparam int ST_FULL    = 0;
  localparam int ST_EMPTY   = 1;
  localparam int ST_OVFP    = 2;
  localparam int ST_MATCHP  = 3;
  localparam int ST_EMPP    = 4;

  typedef enum logic [2:0] {
    ACT_LOW      = 3'd0,
    ACT_HIGH     = 3'd1,
    ACT_BELOW_HI = 3'd2,
    ACT_BELOW_LO = 3'd3,
    ACT_TOGGLE   = 3'd4
  } act_e;
endpackage

// File: rtl/pwm_tick_counter.sv
module pwm_tick_counter #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             updown_i,
  input  logic [PRE_W-1:0] presc_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o,
  output logic             wrap_o
);
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             up_q;

  assign tick_o = en_i && (pre_q >= presc_i);
  assign wrap_o = tick_o && (updown_i ? (!up_q && cnt_q == '0) : (cnt_q >= period_i));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (clr_i || !en_i) begin
      pre_q <= '0;
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      pre_q <= tick_o ? '0 : pre_q + 1'b1;
      if (tick_o) begin
        if (!updown_i) begin
          cnt_q <= (cnt_q >= period_i) ? '0 : cnt_q + 1'b1;
        end else if (up_q) begin
          if (cnt_q >= period_i) begin
            up_q  <= 1'b0;
            cnt_q <= cnt_q - 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else if (cnt_q == '0) begin
          up_q  <= 1'b1;
          cnt_q <= CNT_W'(1);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwm_duty_fifo.sv
module pwm_duty_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int FC_W  = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            push_i,
  input  logic [W-1:0]    wdata_i,
  input  logic            pop_i,
  output logic [W-1:0]    rdata_o,
  output logic            full_o,
  output logic            empty_o,
  output logic [FC_W-1:0] count_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [FC_W-1:0]  cnt_q;
  logic             push_ok, pop_ok;

  assign full_o  = (cnt_q == FC_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
  assign rdata_o = mem_q[rd_ptr_q];
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= nxt(rd_ptr_q);
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_mem
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       mem_q[i] <= '0;
      else if (push_ok && wr_ptr_q == PTR_W'(i) && !clr_i) mem_q[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/pwm_cmp_out.sv
module pwm_cmp_out
  import pwm_fifo_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [2:0]       act_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             match_i,
  input  logic             ovr_en_i,
  input  logic             ovr_lvl_i,
  output logic             pwm_o
);
  logic tgl_q;
  logic lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    tgl_q <= 1'b0;
    else if (clr_i)                                 tgl_q <= 1'b0;
    else if (match_i && act_e'(act_i) == ACT_TOGGLE) tgl_q <= !tgl_q;
  end

  always_comb begin
    case (act_e'(act_i))
      ACT_HIGH:     lvl = 1'b1;
      ACT_BELOW_HI: lvl = (cnt_i < duty_i);
      ACT_BELOW_LO: lvl = !(cnt_i < duty_i);
      ACT_TOGGLE:   lvl = tgl_q;
      default:      lvl = 1'b0;
    endcase
  end

  assign pwm_o = ovr_en_i ? ovr_lvl_i : lvl;
endmodule

// File: rtl/pwm_fifo_channel.sv
module pwm_fifo_channel
  import pwm_fifo_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int PRE_W      = 12,
  parameter int FIFO_DEPTH = 8,
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 32,
  localparam int FC_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pwm_o,
  output logic              irq_o
);
  logic             srst_q, en_q, updown_q, ovf_ie_q, gie_q;
  logic [PRE_W-1:0] presc_q;
  logic [CNT_W-1:0] period_q, shadow_q, duty_act_q;
  logic             ovr_en_q, ovr_lvl_q;
  logic             fifo_mode_q, evt_ie_q, emp_ie_q;
  logic [2:0]       act_q;
  logic             ovf_p_q, match_p_q, emp_p_q;

  logic [CNT_W-1:0] cnt, fifo_rdata, wr_duty_val;
  logic             tick, wrap, match;
  logic             fifo_full, fifo_empty;
  logic [FC_W-1:0]  fifo_cnt;
  logic             wr_tctrl, wr_period, wr_duty, wr_chctrl, wr_status;
  logic             duty_ok, push, pop, emp_set;
  logic             unused_wdata;

  assign wr_tctrl    = wr_en_i && addr_i == ADDR_W'(A_TCTRL);
  assign wr_period   = wr_en_i && addr_i == ADDR_W'(A_PERIOD);
  assign wr_duty     = wr_en_i && addr_i == ADDR_W'(A_DUTY);
  assign wr_chctrl   = wr_en_i && addr_i == ADDR_W'(A_CHCTRL);
  assign wr_status   = wr_en_i && addr_i == ADDR_W'(A_STATUS);
  assign wr_duty_val = wdata_i[CNT_W-1:0];
  assign duty_ok     = wr_duty_val <= period_q;
  assign push        = wr_duty && duty_ok && fifo_mode_q;
  assign pop         = en_q && wrap && fifo_mode_q;
  assign match       = tick && (cnt == duty_act_q);
  assign emp_set     = pop && !fifo_empty && (fifo_cnt == FC_W'(1)) && !push;
  assign unused_wdata = ^wdata_i;

  pwm_tick_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cnt (
    .clk_i, .rst_ni, .clr_i(srst_q), .en_i(en_q), .updown_i(updown_q),
    .presc_i(presc_q), .period_i(period_q), .cnt_o(cnt), .tick_o(tick), .wrap_o(wrap)
  );

  pwm_duty_fifo #(.W(CNT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .clr_i(srst_q), .push_i(push), .wdata_i(wr_duty_val), .pop_i(pop),
    .rdata_o(fifo_rdata), .full_o(fifo_full), .empty_o(fifo_empty), .count_o(fifo_cnt)
  );

  pwm_cmp_out #(.CNT_W(CNT_W)) u_out (
    .clk_i, .rst_ni, .clr_i(srst_q), .act_i(act_q), .cnt_i(cnt), .duty_i(duty_act_q),
    .match_i(match), .ovr_en_i(ovr_en_q), .ovr_lvl_i(ovr_lvl_q), .pwm_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srst_q <= 1'b0; en_q <= 1'b0; updown_q <= 1'b0; ovf_ie_q <= 1'b0; gie_q <= 1'b0;
      presc_q <= '0; period_q <= '1; shadow_q <= '0;
      ovr_en_q <= 1'b0; ovr_lvl_q <= 1'b0;
      fifo_mode_q <= 1'b0; act_q <= 3'd0; evt_ie_q <= 1'b0; emp_ie_q <= 1'b0;
    end else begin
      srst_q <= wr_tctrl && wdata_i[TC_SRST];
      if (wr_tctrl) begin
        en_q     <= wdata_i[TC_EN];
        updown_q <= wdata_i[TC_UD];
        ovf_ie_q <= wdata_i[TC_OVFIE];
        gie_q    <= wdata_i[TC_GIE];
        presc_q  <= wdata_i[TC_PRE_LSB +: PRE_W];
      end
      if (wr_period && wdata_i[CNT_W-1:0] != '0) period_q <= wdata_i[CNT_W-1:0];
      if (wr_duty) begin
        ovr_en_q  <= wdata_i[DU_OVR_EN];
        ovr_lvl_q <= wdata_i[DU_OVR_LVL];
        if (duty_ok && !fifo_mode_q) shadow_q <= wr_duty_val;
      end
      if (wr_chctrl) begin
        fifo_mode_q <= wdata_i[CC_FIFO];
        act_q       <= wdata_i[CC_ACT_LSB +: 3];
        evt_ie_q    <= wdata_i[CC_EVTIE];
        emp_ie_q    <= wdata_i[CC_EMPIE];
      end
    end
  end

  // active duty and sticky flags (set wins over clear)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_act_q <= '0;
      ovf_p_q <= 1'b0; match_p_q <= 1'b0; emp_p_q <= 1'b0;
    end else if (srst_q) begin
      duty_act_q <= '0;
      ovf_p_q <= 1'b0; match_p_q <= 1'b0; emp_p_q <= 1'b0;
    end else begin
      if (!en_q) begin
        if (!fifo_mode_q) duty_act_q <= shadow_q;
      end else if (wrap) begin
        if (!fifo_mode_q)     duty_act_q <= shadow_q;
        else if (!fifo_empty) duty_act_q <= fifo_rdata;
      end
      ovf_p_q   <= wrap    || (ovf_p_q   && !(wr_status && wdata_i[ST_OVFP]));
      match_p_q <= match   || (match_p_q && !(wr_status && wdata_i[ST_MATCHP]));
      emp_p_q   <= emp_set || (emp_p_q   && !(wr_status && wdata_i[ST_EMPP]));
    end
  end

  assign irq_o = (ovf_p_q && ovf_ie_q && gie_q) || (match_p_q && evt_ie_q) || (emp_p_q && emp_ie_q);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(A_TCTRL): begin
        rdata_o[TC_SRST]  = srst_q;
        rdata_o[TC_EN]    = en_q;
        rdata_o[TC_UD]    = updown_q;
        rdata_o[TC_OVFIE] = ovf_ie_q;
        rdata_o[TC_GIE]   = gie_q;
        rdata_o[TC_PRE_LSB +: PRE_W] = presc_q;
      end
      ADDR_W'(A_PERIOD): rdata_o[CNT_W-1:0] = period_q;
      ADDR_W'(A_DUTY): begin
        rdata_o[CNT_W-1:0]  = shadow_q;
        rdata_o[DU_OVR_EN]  = ovr_en_q;
        rdata_o[DU_OVR_LVL] = ovr_lvl_q;
      end
      ADDR_W'(A_CHCTRL): begin
        rdata_o[CC_FIFO]           = fifo_mode_q;
        rdata_o[CC_ACT_LSB +: 3]   = act_q;
        rdata_o[CC_EVTIE]          = evt_ie_q;
        rdata_o[CC_EMPIE]          = emp_ie_q;
      end
      ADDR_W'(A_STATUS): begin
        rdata_o[ST_FULL]   = fifo_full;
        rdata_o[ST_EMPTY]  = fifo_empty;
        rdata_o[ST_OVFP]   = ovf_p_q;
        rdata_o[ST_MATCHP] = match_p_q;
        rdata_o[ST_EMPP]   = emp_p_q;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pwm_fifo_channel_checker.sv
module pwm_fifo_channel_checker
  import pwm_fifo_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int FC_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              srst_i,
  input logic              en_i,
  input logic              wrap_i,
  input logic              updown_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  duty_act_i,
  input logic              fifo_full_i,
  input logic              fifo_empty_i,
  input logic              fifo_mode_i,
  input logic              push_i,
  input logic              pop_i,
  input logic [FC_W-1:0]   fifo_cnt_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [CNT_W-1:0]  period_i,
  input logic [CNT_W-1:0]  shadow_i,
  input logic              gie_i,
  input logic              evt_ie_i,
  input logic              emp_ie_i,
  input logic              irq_i
);
  assert_srst_selfclear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> !srst_i);

  assert_full_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_full_i && push_i && !pop_i && !srst_i) |=> (fifo_cnt_i == $past(fifo_cnt_i)));

  assert_big_duty_dropped_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(A_DUTY) && !fifo_mode_i && wdata_i[CNT_W-1:0] > period_i)
    |=> $stable(shadow_i));

  assert_duty_at_boundary_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wrap_i && !srst_i) |=> $stable(duty_act_i));

  assert_empty_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wrap_i && fifo_mode_i && fifo_empty_i && !srst_i) |=> $stable(duty_act_i));

  assert_updown_wrap_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && updown_i) |-> (cnt_i == '0));

  assert_irq_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gie_i && !evt_ie_i && !emp_ie_i) |-> !irq_i);
endmodule

bind pwm_fifo_channel pwm_fifo_channel_checker #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FC_W(FC_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst_q), .en_i(en_q), .wrap_i(wrap),
  .updown_i(updown_q), .cnt_i(cnt), .duty_act_i(duty_act_q), .fifo_full_i(fifo_full),
  .fifo_empty_i(fifo_empty), .fifo_mode_i(fifo_mode_q), .push_i(push), .pop_i(pop),
  .fifo_cnt_i(fifo_cnt), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .period_i(period_q), .shadow_i(shadow_q), .gie_i(gie_q), .evt_ie_i(evt_ie_q),
  .emp_ie_i(emp_ie_q), .irq_i(irq_o)
);

// File: tb/pwm_fifo_channel_bench.sv
module pwm_fifo_channel_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        pwm_o, irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  int blk [16];

  always #2 clk_i = !clk_i;

  pwm_fifo_channel u_pwm_fifo_channel (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o, .pwm_o, .irq_o
  );

  // updown, prescale, period, duty, action, window, expected high clocks
  localparam int NV = 10;
  localparam int VEC [NV][7] = '{
    '{0, 0, 9, 3, 2, 40, 12},
    '{0, 2, 4, 2, 2, 60, 24},
    '{0, 0, 1, 1, 2,  8,  4},
    '{1, 0, 6, 2, 2, 48, 12},
    '{1, 1, 5, 5, 2, 80, 72},
    '{1, 0, 3, 0, 2, 24,  0},
    '{0, 0, 7, 3, 3, 32, 20},
    '{0, 0, 7, 3, 1, 32, 32},
    '{0, 0, 7, 3, 0, 32,  0},
    '{0, 0, 7, 3, 4, 32, 16}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    addr_i = a[2:0]; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr_i = a[2:0];
    #1 d = rdata_o;
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      h += int'(pwm_o);
    end
  endtask

  // sync on a rising pwm edge, then count highs in consecutive blocks
  task automatic meas_blocks(input int nb, input int len, input int wr_at, input logic [31:0] wd);
    logic prev;
    prev = 1'b1;
    for (int i = 0; i < 16; i++) blk[i] = 0;
    for (int t = 0; t < 400; t++) begin
      @(negedge clk_i);
      if (!prev && pwm_o) break;
      prev = pwm_o;
    end
    for (int k = 0; k < nb * len; k++) begin
      if (k > 0) @(negedge clk_i);
      blk[k / len] += int'(pwm_o);
      if (k == wr_at) begin addr_i = 3'd2; wdata_i = wd; wr_en_i = 1'b1; end
      if (k == wr_at + 1) wr_en_i = 1'b0;
    end
    wr_en_i = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int h;
    int exp_fifo [10] = '{2, 5, 1, 7, 3, 6, 4, 8, 8, 8};
    string req;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R12 reset state
    chk("R12", "pwm_o after reset", int'(pwm_o), 0);
    chk("R12", "irq_o after reset", int'(irq_o), 0);
    rd(1, d); chk("R12", "period after reset", int'(d), 32'hFFFF);
    rd(4, d); chk("R12", "status after reset", int'(d), 2);
    @(negedge clk_i);
    wr(1, 0);
    rd(1, d); chk("R1", "period zero write ignored", int'(d), 32'hFFFF);
    @(negedge clk_i);

    // vector table: duty measured as high clocks over whole periods
    for (int v = 0; v < NV; v++) begin
      logic [31:0] tc;
      tc = (32'(VEC[v][0]) << 2) | (32'(VEC[v][1]) << 16);
      wr(0, tc);
      wr(1, 32'(VEC[v][2]));
      wr(3, 32'(VEC[v][4]) << 1);
      wr(2, 32'(VEC[v][3]));
      wr(0, tc | 32'h2);
      repeat (VEC[v][5]) @(negedge clk_i);
      count_high(VEC[v][5], h);
      req = (VEC[v][4] != 2) ? "R3" : (VEC[v][0] != 0 ? "R2" : "R1");
      chk(req, $sformatf("vector %0d high clocks", v), h, VEC[v][6]);
    end

    // R6: oversize duty ignored
    wr(0, 0); wr(1, 9); wr(3, 2 << 1); wr(2, 3); wr(0, 2);
    wr(2, 12);
    rd(2, d); chk("R6", "shadow after oversize write", int'(d[15:0]), 3);
    @(negedge clk_i);
    count_high(40, h); chk("R6", "highs after oversize write", h, 12);

    // R7: mid-period write takes effect at next boundary
    meas_blocks(2, 10, 3, 32'd6);
    chk("R7", "period of mid write", blk[0], 3);
    chk("R7", "following period", blk[1], 6);

    // R8: up-down overflow flagged at zero, gated by enables
    wr(0, 32'h0000_000C);           // updown, ovf_ie, disabled
    wr(3, 2 << 1);
    wr(1, 6);
    wr(4, 32'h1C);
    wr(0, 32'h0000_000E);           // enable
    repeat (9) @(negedge clk_i);
    rd(4, d); chk("R8", "ovf pending before zero", int'(d[2]), 0);
    repeat (5) @(negedge clk_i);
    rd(4, d); chk("R8", "ovf pending at zero", int'(d[2]), 1);
    chk("R8", "irq without global enable", int'(irq_o), 0);
    @(negedge clk_i);
    wr(0, 32'h0000_001C);           // stop, gie + ovf_ie
    chk("R8", "irq with both enables", int'(irq_o), 1);
    wr(4, 32'h04);
    chk("R9", "irq after W1C", int'(irq_o), 0);

    // R9: compare match event
    wr(1, 9); wr(2, 3);
    wr(4, 32'h1C);
    wr(3, (2 << 1) | (1 << 4));
    wr(0, 2);
    repeat (20) @(negedge clk_i);
    rd(4, d); chk("R9", "match pending", int'(d[3]), 1);
    chk("R9", "match irq", int'(irq_o), 1);
    @(negedge clk_i);
    wr(0, 0); wr(3, 2 << 1);
    chk("R9", "irq after match enable off", int'(irq_o), 0);

    // R4/R5: FIFO streaming
    wr(2, 0);
    repeat (2) @(negedge clk_i);
    wr(3, 1 | (2 << 1) | (1 << 5));
    for (int i = 0; i < 8; i++) wr(2, 32'(exp_fifo[i]));
    rd(4, d); chk("R5", "full flag after 8 pushes", int'(d[0]), 1);
    @(negedge clk_i);
    wr(2, 9);                       // dropped
    wr(4, 32'h1C);
    wr(0, 2);
    meas_blocks(10, 10, -1, 32'd0);
    for (int i = 0; i < 10; i++)
      chk(i < 8 ? "R4" : "R5", $sformatf("fifo period %0d highs", i), blk[i], exp_fifo[i]);
    rd(4, d); chk("R9", "drain pending", int'(d[4]), 1);
    chk("R9", "drain irq", int'(irq_o), 1);
    @(negedge clk_i);

    // R10: soft reset
    wr(0, 0);
    wr(2, 1); wr(2, 2); wr(2, 3);
    rd(4, d); chk("R10", "fifo not empty before soft reset", int'(d[1]), 0);
    @(negedge clk_i);
    wr(0, 1);
    rd(0, d); chk("R10", "soft reset bit set", int'(d[0]), 1);
    @(negedge clk_i);
    rd(0, d); chk("R10", "soft reset bit cleared", int'(d[0]), 0);
    rd(4, d); chk("R10", "status after soft reset", int'(d), 2);
    @(negedge clk_i);

    // R11: output override
    wr(3, 0);
    wr(2, 32'h0003_0000);
    chk("R11", "override high over action low", int'(pwm_o), 1);
    wr(3, 1 << 1);
    wr(2, 32'h0001_0000);
    chk("R11", "override low over action high", int'(pwm_o), 0);
    wr(2, 0);
    chk("R11", "override released", int'(pwm_o), 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule